// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host and an external 64K x 16 asynchronous static RAM. Each host request is a single-cycle handshake that carries an address, write data, a write flag and a two-bit lane mask. The block turns that request into a timed sequence on the memory's active-low control pins. It holds the chip deselected while idle. Reads are timed from a parameterised access time, and each read is followed by a float gap before the bus may be driven again. Writes put the data on the bus one clock before the write strobe falls and keep it there for one clock after the strobe rises.

The sequencer has six states. ST_IDLE (ready high, chip deselected) moves to ST_RD_ACCESS on a read request, or to ST_WR_SETUP on a write request. ST_RD_ACCESS drives chip enable and output enable low for the read wait count, captures the data on its last cycle and moves to ST_RD_FLOAT. ST_RD_FLOAT deselects the chip for the float count and then returns to ST_IDLE. ST_WR_SETUP drives the data with the strobe high for one clock, then moves to ST_WR_STROBE. ST_WR_STROBE holds the write strobe low for the write count and moves to ST_WR_HOLD. ST_WR_HOLD keeps the data on the bus for one clock and returns to ST_IDLE.

Each wait count is ceil(time_ns / clock_period_ns), with a minimum of one clock. Lane bit 0 of every mask and select vector is the low byte (data bits 7:0). Lane bit 1 is the high byte (bits 15:8).

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and between transfers, host_ready is 1, mem_ce_n, mem_oe_n, mem_we_n and both mem_lane_n bits are 1, mem_dq_oe is 0 and host_rvalid is 0.
- R2: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly the read wait count of clocks, starting the clock after acceptance, with mem_lane_n equal to the inverted mask and mem_addr equal to the request address.
- R3: The read word is sampled at the end of the read window. A lane whose mask bit is 0 returns zeros in host_rdata (bit 0 of the mask selects bits 7:0, bit 1 selects bits 15:8).
- R4: host_rvalid is 1 for exactly one clock, the clock right after the read window ends, and at no other time.
- R5: After a read the chip is deselected (mem_ce_n=1, mem_oe_n=1, mem_dq_oe=0) and host_ready stays 0 for the float count of clocks.
- R6: A write is one setup clock (mem_ce_n=0, mem_we_n=1, data driven), then mem_we_n=0 for exactly the write count of clocks, then one hold clock with the data still driven. mem_oe_n stays 1 throughout and mem_dq_out equals the request data.
- R7: A lane whose mask bit is 0 keeps its select high during a write, and the memory byte in that lane is left unchanged.
- R8: host_ready is 0 from the clock after acceptance until the sequence returns to idle. A request presented while host_ready is 0 starts nothing.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0.
- R10: The read, write and float counts equal ceil(ns/period) of their parameters, with a minimum of 1. With the default parameters (4 ns clock, 10, 8 and 5 ns) these are 3, 2 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request; accepted when host_ready is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Lane mask, bit 0 = bits 7:0 |
| host_ready | output | 1 | Idle and able to accept a request |
| host_rdata | output | 16 | Captured read word, unselected lanes zero |
| host_rvalid | output | 1 | One-clock read-data strobe |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Lane selects, active low, bit 0 = low byte |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |

## Verification
The bound checker watches the pin rules on every cycle:
- the chip is deselected whenever the block is ready;
- the controller never drives the bus while output enable is low;
- data is driven throughout the write strobe, including the clock before it falls and the clock after it rises;
- the output-enable window and the write strobe have exactly their computed lengths;
- read-valid is a single-clock pulse that follows an output-enable window.

Only the bench scenarios can show that the right bytes reach the memory and come back with unselected lanes zeroed. The same holds for the float gap after a read and for requests made while busy being ignored. The bench checks these against its own model of the memory contents.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_FLOAT,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_HOLD
    } seq_state_t;

    // Clocks needed to cover a time in ns, never fewer than one.
    function automatic int unsigned wait_cycles(input int unsigned span_ns,
                                                input int unsigned period_ns);
        int unsigned q;
        q = (span_ns + period_ns - 1) / period_ns;
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [LANES-1:0]        lane_en,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= capture;
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned LANES         = 2,
    parameter int unsigned LANE_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned RD_ACCESS_NS  = 10,
    parameter int unsigned WR_PULSE_NS   = 8,
    parameter int unsigned BUS_FLOAT_NS  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [LANES*LANE_W-1:0] host_wdata,
    input  logic [LANES-1:0]        host_be,
    output logic                    host_ready,
    output logic [LANES*LANE_W-1:0] host_rdata,
    output logic                    host_rvalid,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic                    mem_we_n,
    output logic [LANES-1:0]        mem_lane_n,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    input  logic [LANES*LANE_W-1:0] mem_dq_in,
    output logic                    mem_dq_oe
);

    localparam int unsigned DATA_W   = LANES * LANE_W;
    localparam int unsigned RD_CYC   = wait_cycles(RD_ACCESS_NS, CLK_PERIOD_NS);
    localparam int unsigned WR_CYC   = wait_cycles(WR_PULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned TURN_CYC = wait_cycles(BUS_FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC  = (RD_CYC > WR_CYC)
                                     ? ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC)
                                     : ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = RD_CYC[CNT_W-1:0];
    localparam logic [CNT_W-1:0] WR_LOAD   = WR_CYC[CNT_W-1:0];
    localparam logic [CNT_W-1:0] TURN_LOAD = TURN_CYC[CNT_W-1:0];

    seq_state_t          state_q, state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    be_q;
    logic                accept;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_last;
    logic                capture;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch, loaded only on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            be_q    <= host_be;
        end
    end

    // Transitions and wait-timer loads
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    accept = 1'b1;
                    if (host_we) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) begin
                    state_d  = ST_RD_FLOAT;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LOAD;
                end
            end
            ST_RD_FLOAT: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_STROBE;
                tmr_load = 1'b1;
                tmr_val  = WR_LOAD;
            end
            ST_WR_STROBE: begin
                if (tmr_last) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin decode
    always_comb begin
        host_ready = 1'b0;
        mem_ce_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_lane_n = '1;
        mem_dq_oe  = 1'b0;
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
        unique case (state_q)
            ST_IDLE:      host_ready = 1'b1;
            ST_RD_ACCESS: begin
                mem_ce_n   = 1'b0;
                mem_oe_n   = 1'b0;
                mem_lane_n = ~be_q;
            end
            ST_RD_FLOAT:  ;
            ST_WR_SETUP, ST_WR_HOLD: begin
                mem_ce_n   = 1'b0;
                mem_lane_n = ~be_q;
                mem_dq_oe  = 1'b1;
            end
            ST_WR_STROBE: begin
                mem_ce_n   = 1'b0;
                mem_we_n   = 1'b0;
                mem_lane_n = ~be_q;
                mem_dq_oe  = 1'b1;
            end
            default: ;
        endcase
    end

    assign capture = (state_q == ST_RD_ACCESS) && tmr_last;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_read_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lane_en (be_q),
        .dq_in   (mem_dq_in),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned RD_CYC = 3,
    parameter int unsigned WR_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic host_ready,
    input logic host_rvalid,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe
);

    logic [7:0] oe_run_q;
    logic [7:0] we_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run_q <= '0;
            we_run_q <= '0;
        end else begin
            oe_run_q <= mem_oe_n ? 8'd0 : oe_run_q + 8'd1;
            we_run_q <= mem_we_n ? 8'd0 : we_run_q + 8'd1;
        end
    end

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !host_ready);

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R6
    strobe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_oe_n));

    // R6
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    // R6
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == WR_CYC[7:0]));

    // R2
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run_q == RD_CYC[7:0]));

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    // R4
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> ($past(!mem_oe_n) && mem_oe_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

    localparam int unsigned T_CLK = 4;
    localparam int unsigned T_RD  = 10;
    localparam int unsigned T_WR  = 8;
    localparam int unsigned T_FLT = 5;

    function automatic int unsigned cyc(input int unsigned ns, input int unsigned per);
        int unsigned q;
        q = (ns + per - 1) / per;
        return (q == 0) ? 1 : q;
    endfunction

    localparam int unsigned RD_N = cyc(T_RD, T_CLK);
    localparam int unsigned WR_N = cyc(T_WR, T_CLK);
    localparam int unsigned FL_N = cyc(T_FLT, T_CLK);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ready, host_rvalid;
    logic [15:0] host_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_addr, mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sram_lane_ctrl #(
        .CLK_PERIOD_NS(T_CLK), .RD_ACCESS_NS(T_RD),
        .WR_PULSE_NS(T_WR), .BUS_FLOAT_NS(T_FLT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Memory model (low 8 address bits) and independent reference copy
    logic [15:0] sram    [0:255];
    logic [15:0] ref_mem [0:255];

    function automatic logic [15:0] init_word(input int i);
        return 16'(i * 16'h0101) ^ 16'h3C5A;
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            sram[i]    = init_word(i);
            ref_mem[i] = init_word(i);
        end
    end

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lane_n[0]) sram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_lane_n[1]) sram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    // Unselected or floating lanes return junk so masking is visible
    always_comb begin
        logic rd_on;
        rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
        mem_dq_in[7:0]  = (rd_on && !mem_lane_n[0]) ? sram[mem_addr[7:0]][7:0]  : 8'hA5;
        mem_dq_in[15:8] = (rd_on && !mem_lane_n[1]) ? sram[mem_addr[7:0]][15:8] : 8'hA5;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // R9 watched every cycle
    always @(negedge clk) begin
        if (rst_n && mem_dq_oe && !mem_oe_n) begin
            checks++;
            fails++;
            $display("FAIL R9: actual dq_oe=1 oe_n=0 expected no overlap at %0t", $time);
        end
    end

    task automatic chk_idle();
        chk("R1 idle pins", {27'd0, host_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
            {27'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0});
        chk("R1 idle lanes", {30'd0, mem_lane_n}, 32'd3);
        chk("R1 idle rvalid", {31'd0, host_rvalid}, 32'd0);
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic do_read(input logic [15:0] a, input logic [1:0] be, input bit poke);
        logic [15:0] exp;
        exp = ref_mem[a[7:0]] & lane_mask(be);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a; host_be = be;
        host_wdata = 16'($urandom);
        @(negedge clk);
        if (poke) begin
            // R8: a write request presented while busy must start nothing
            host_req = 1'b1; host_we = 1'b1; host_addr = ~a; host_be = 2'b11;
        end else begin
            host_req = 1'b0;
        end
        for (int i = 0; i < int'(RD_N); i++) begin
            chk("R2 read pins", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, host_ready},
                {28'd0, 1'b0, 1'b0, 1'b1, 1'b0});
            chk("R2 read lanes", {30'd0, mem_lane_n}, {30'd0, ~be});
            chk("R2 read addr", {16'd0, mem_addr}, {16'd0, a});
            chk("R4 no early rvalid", {31'd0, host_rvalid}, 32'd0);
            @(negedge clk);
        end
        chk("R4 rvalid pulse", {31'd0, host_rvalid}, 32'd1);
        chk("R3 read data", {16'd0, host_rdata}, {16'd0, exp});
        for (int i = 0; i < int'(FL_N); i++) begin
            chk("R5 float", {28'd0, host_ready, mem_ce_n, mem_oe_n, mem_dq_oe},
                {28'd0, 1'b0, 1'b1, 1'b1, 1'b0});
            chk("R8 no strobe while busy", {31'd0, mem_we_n}, 32'd1);
            if (i > 0) chk("R4 single pulse", {31'd0, host_rvalid}, 32'd0);
            if (i == int'(FL_N) - 1) host_req = 1'b0;
            @(negedge clk);
        end
        chk_idle();
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_be = be; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        chk("R6 setup", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
            {28'd0, 1'b0, 1'b1, 1'b1, 1'b1});
        chk("R6 data", {16'd0, mem_dq_out}, {16'd0, d});
        chk("R7 write lanes", {30'd0, mem_lane_n}, {30'd0, ~be});
        chk("R8 busy", {31'd0, host_ready}, 32'd0);
        @(negedge clk);
        for (int i = 0; i < int'(WR_N); i++) begin
            chk("R6 strobe", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
                {28'd0, 1'b0, 1'b1, 1'b0, 1'b1});
            chk("R6 addr", {16'd0, mem_addr}, {16'd0, a});
            @(negedge clk);
        end
        chk("R6 hold", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
            {28'd0, 1'b0, 1'b1, 1'b1, 1'b1});
        chk("R6 hold data", {16'd0, mem_dq_out}, {16'd0, d});
        @(negedge clk);
        chk_idle();
        if (be[0]) ref_mem[a[7:0]][7:0]  = d[7:0];
        if (be[1]) ref_mem[a[7:0]][15:8] = d[15:8];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_idle();
        chk("R1 reset rdata", {16'd0, host_rdata}, 32'd0);
        // R10 derived counts
        chk("R10 counts", {8'd0, 8'(RD_N), 8'(WR_N), 8'(FL_N)}, {8'd0, 8'd3, 8'd2, 8'd2});

        // Directed corners
        do_write(16'h0000, 16'hBEEF, 2'b11);
        do_read (16'h0000, 2'b11, 0);
        do_write(16'hFFFF, 16'h1234, 2'b01);            // R7 low lane only
        do_read (16'hFFFF, 2'b11, 0);
        do_write(16'h8042, 16'hCAFE, 2'b10);            // R7 high lane only
        do_read (16'h8042, 2'b11, 0);
        do_write(16'h0010, 16'h5555, 2'b00);            // R7 no lanes
        do_read (16'h0010, 2'b11, 0);
        do_read (16'h0000, 2'b01, 0);                   // R3 high lane zero
        do_read (16'h0000, 2'b10, 0);                   // R3 low lane zero
        do_read (16'h0000, 2'b00, 0);                   // R3 all zero
        do_read (16'h0000, 2'b11, 1);                   // R8 request while busy
        do_read (16'h00FF, 2'b11, 0);                   // R8 poke left memory intact

        // Constrained random mix
        for (int n = 0; n < 60; n++) begin
            logic [15:0] a;
            a = 16'($urandom);
            if ($urandom_range(0, 1) == 1)
                do_write(a, 16'($urandom), 2'($urandom));
            else
                do_read(a, 2'($urandom), $urandom_range(0, 3) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule